// File: doc/BRIEF.md
# Serial Sharer Invalidation Sequencer

This block sits beside one cache and obtains write ownership of a line whose sharers are kept as a singly linked chain. Memory keeps only the chain's head pointer, and each cache keeps the pointer to the sharer after it. When the local processor asks to write a line it does not own, the sequencer may first take itself out of the chain. It then announces its write intent to memory, which makes it the new head and returns the previous head.

From the previous head it walks the chain one node at a time. It sends one invalidation, waits for the acknowledgement, and takes the next target from the pointer carried in that acknowledgement. When a pointer equal to the reserved null value arrives, ownership is granted. Each outgoing message is a one-cycle valid pulse, and each incoming response is a one-cycle valid pulse. Responses that do not match the outstanding request are flagged and dropped.

Top module: `sinv_seq`

## Requirements
- R1: During and after reset busy_o, tx_valid_o, grant_o and proto_err_o are low, and while busy_o is low no message and no grant is produced.
- R2: A request with is_sharer_i high and pred_i not null first sends message type 0 (unlink) to pred_i with tx_ptr_o equal to own_next_i, then waits for a response of type 0 whose source is pred_i.
- R3: Write intent, message type 1, goes to node MEM_NODE with tx_ptr_o equal to NODE_ID. It is sent directly after acceptance when no unlink is needed, and otherwise directly after the unlink confirmation.
- R4: The head response (type 1 from MEM_NODE) supplies the first invalidation target in rx_ptr_i. When that pointer equals NODE_ID, the own_next_i value captured at acceptance is used instead.
- R5: Each invalidation is message type 2 sent to the current target with tx_ptr_o equal to NODE_ID. An acknowledgement of type 2 whose source is that target supplies the next target in rx_ptr_i.
- R6: A resolved pointer equal to the null value (all ones) ends the walk. grant_o is high for exactly one cycle, the cycle after the response that carried it, and is never high together with tx_valid_o.
- R7: A response that does not match the outstanding type and source, or that arrives when no response is awaited, raises proto_err_o for one cycle in the next cycle. It is otherwise ignored: no message is sent, and the next correct acknowledgement is still accepted from the same target.
- R8: wr_req_i is ignored while busy_o is high.
- R9: Every message is a one-cycle pulse, and the next message is sent only after a matching response has been taken.
- R10: Every message carries in tx_line_o the line address captured with the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_req_i | input | 1 | Request write ownership (one cycle) |
| wr_line_i | input | ADDR_W | Line address of the request |
| is_sharer_i | input | 1 | Local cache currently holds a shared copy |
| pred_i | input | NODE_W | Predecessor in the chain, null when local node is head |
| own_next_i | input | NODE_W | Local next pointer for this line |
| busy_o | output | 1 | Sequence in progress |
| grant_o | output | 1 | Ownership granted (one cycle) |
| proto_err_o | output | 1 | Unexpected response seen (one cycle) |
| tx_valid_o | output | 1 | Outgoing message valid |
| tx_type_o | output | 2 | 0 unlink, 1 write intent, 2 invalidate |
| tx_dst_o | output | NODE_W | Destination node |
| tx_ptr_o | output | NODE_W | Pointer field of the message |
| tx_line_o | output | ADDR_W | Line address of the message |
| rx_valid_i | input | 1 | Incoming response valid |
| rx_type_i | input | 2 | 0 unlink done, 1 head reply, 2 invalidate ack |
| rx_src_i | input | NODE_W | Source node of the response |
| rx_ptr_i | input | NODE_W | Pointer carried by the response |

## Verification
Two functions can share a cycle: the terminating acknowledgement that ends the walk, and a fresh wr_req_i that the block must refuse because it is still busy. The bench raises wr_req_i in the same cycle as the final acknowledgement. It then expects the grant pulse one cycle later and an idle, silent block after that, with no new unlink or intent message. Stray acknowledgements from the wrong node are also placed in the wait cycle just before the correct one. The bench checks the error flag, confirms that no message is sent, and checks that the walk continues to the expected next node.

// File: rtl/sinv_pkg.sv
package sinv_pkg;
  typedef enum logic [1:0] {
    TX_UNLINK = 2'd0,
    TX_INTENT = 2'd1,
    TX_INVAL  = 2'd2
  } tx_kind_e;

  typedef enum logic [1:0] {
    RX_UNLINK_DONE = 2'd0,
    RX_HEAD        = 2'd1,
    RX_INV_ACK     = 2'd2
  } rx_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLINK_TX,
    ST_UNLINK_WT,
    ST_INTENT_TX,
    ST_INTENT_WT,
    ST_INV_TX,
    ST_INV_WT,
    ST_GRANT
  } st_e;
endpackage

// File: rtl/sinv_walk_fsm.sv
module sinv_walk_fsm
  import sinv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic unlink_i,
  input  logic rsp_ok_i,
  input  logic nxt_null_i,
  output st_e  st_o
);
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (start_i) st_d = unlink_i ? ST_UNLINK_TX : ST_INTENT_TX;
      ST_UNLINK_TX: st_d = ST_UNLINK_WT;
      ST_UNLINK_WT: if (rsp_ok_i) st_d = ST_INTENT_TX;
      ST_INTENT_TX: st_d = ST_INTENT_WT;
      ST_INTENT_WT: if (rsp_ok_i) st_d = nxt_null_i ? ST_GRANT : ST_INV_TX;
      ST_INV_TX:    st_d = ST_INV_WT;
      ST_INV_WT:    if (rsp_ok_i) st_d = nxt_null_i ? ST_GRANT : ST_INV_TX;
      ST_GRANT:     st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/sinv_target_trk.sv
module sinv_target_trk
  import sinv_pkg::*;
#(
  parameter int NODE_W   = 4,
  parameter int ADDR_W   = 16,
  parameter int NODE_ID  = 3,
  parameter int MEM_NODE = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               st_i,
  input  logic              start_i,
  input  logic              sharer_i,
  input  logic [NODE_W-1:0] pred_i,
  input  logic [NODE_W-1:0] next_i,
  input  logic [ADDR_W-1:0] line_i,
  input  logic              rx_valid_i,
  input  logic [1:0]        rx_type_i,
  input  logic [NODE_W-1:0] rx_src_i,
  input  logic [NODE_W-1:0] rx_ptr_i,
  output logic              unlink_o,
  output logic              rsp_ok_o,
  output logic              nxt_null_o,
  output logic [NODE_W-1:0] pred_o,
  output logic [NODE_W-1:0] tgt_o,
  output logic [ADDR_W-1:0] line_o,
  output logic              err_o
);
  localparam logic [NODE_W-1:0] NULL_ID = {NODE_W{1'b1}};
  localparam logic [NODE_W-1:0] SELF_ID = NODE_W'(NODE_ID);
  localparam logic [NODE_W-1:0] MEM_ID  = NODE_W'(MEM_NODE);

  logic [NODE_W-1:0] pred_q, next_q, tgt_q, exp_src, resolved;
  logic [ADDR_W-1:0] line_q;
  rx_kind_e          exp_type;
  logic              waiting, err_q;

  assign unlink_o = sharer_i && (pred_i != NULL_ID);

  always_comb begin
    waiting  = 1'b1;
    exp_type = RX_INV_ACK;
    exp_src  = tgt_q;
    unique case (st_i)
      ST_UNLINK_WT: begin exp_type = RX_UNLINK_DONE; exp_src = pred_q; end
      ST_INTENT_WT: begin exp_type = RX_HEAD;        exp_src = MEM_ID; end
      ST_INV_WT:    ;
      default:      waiting = 1'b0;
    endcase
  end

  assign rsp_ok_o = rx_valid_i && waiting && (rx_type_i == exp_type) && (rx_src_i == exp_src);

  // requester was already head: memory returns our own id, walk starts at our next
  assign resolved   = (st_i == ST_INTENT_WT && rx_ptr_i == SELF_ID) ? next_q : rx_ptr_i;
  assign nxt_null_o = (resolved == NULL_ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= NULL_ID;
      next_q <= NULL_ID;
      tgt_q  <= NULL_ID;
      line_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= rx_valid_i && !rsp_ok_o;
      if (start_i) begin
        pred_q <= pred_i;
        next_q <= next_i;
        line_q <= line_i;
      end
      if (rsp_ok_o && st_i != ST_UNLINK_WT) tgt_q <= resolved;
    end
  end

  assign pred_o = pred_q;
  assign tgt_o  = tgt_q;
  assign line_o = line_q;
  assign err_o  = err_q;
endmodule

// File: rtl/sinv_tx_fmt.sv
module sinv_tx_fmt
  import sinv_pkg::*;
#(
  parameter int NODE_W   = 4,
  parameter int NODE_ID  = 3,
  parameter int MEM_NODE = 14
) (
  input  st_e               st_i,
  input  logic [NODE_W-1:0] pred_i,
  input  logic [NODE_W-1:0] next_i,
  input  logic [NODE_W-1:0] tgt_i,
  output logic              valid_o,
  output logic [1:0]        type_o,
  output logic [NODE_W-1:0] dst_o,
  output logic [NODE_W-1:0] ptr_o
);
  always_comb begin
    valid_o = 1'b0;
    type_o  = TX_UNLINK;
    dst_o   = '0;
    ptr_o   = '0;
    unique case (st_i)
      ST_UNLINK_TX: begin
        valid_o = 1'b1; type_o = TX_UNLINK; dst_o = pred_i; ptr_o = next_i;
      end
      ST_INTENT_TX: begin
        valid_o = 1'b1; type_o = TX_INTENT; dst_o = NODE_W'(MEM_NODE); ptr_o = NODE_W'(NODE_ID);
      end
      ST_INV_TX: begin
        valid_o = 1'b1; type_o = TX_INVAL; dst_o = tgt_i; ptr_o = NODE_W'(NODE_ID);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sinv_seq.sv
module sinv_seq
  import sinv_pkg::*;
#(
  parameter int NODE_W   = 4,
  parameter int ADDR_W   = 16,
  parameter int NODE_ID  = 3,
  parameter int MEM_NODE = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_line_i,
  input  logic              is_sharer_i,
  input  logic [NODE_W-1:0] pred_i,
  input  logic [NODE_W-1:0] own_next_i,
  output logic              busy_o,
  output logic              grant_o,
  output logic              proto_err_o,
  output logic              tx_valid_o,
  output logic [1:0]        tx_type_o,
  output logic [NODE_W-1:0] tx_dst_o,
  output logic [NODE_W-1:0] tx_ptr_o,
  output logic [ADDR_W-1:0] tx_line_o,
  input  logic              rx_valid_i,
  input  logic [1:0]        rx_type_i,
  input  logic [NODE_W-1:0] rx_src_i,
  input  logic [NODE_W-1:0] rx_ptr_i
);
  st_e               st;
  logic              start, unlink, rsp_ok, nxt_null;
  logic [NODE_W-1:0] pred_q, tgt_q;

  assign start = wr_req_i && (st == ST_IDLE);

  sinv_walk_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .unlink_i   (unlink),
    .rsp_ok_i   (rsp_ok),
    .nxt_null_i (nxt_null),
    .st_o       (st)
  );

  logic [NODE_W-1:0] next_unused;
  assign next_unused = own_next_i;

  sinv_target_trk #(
    .NODE_W(NODE_W), .ADDR_W(ADDR_W), .NODE_ID(NODE_ID), .MEM_NODE(MEM_NODE)
  ) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_i       (st),
    .start_i    (start),
    .sharer_i   (is_sharer_i),
    .pred_i     (pred_i),
    .next_i     (next_unused),
    .line_i     (wr_line_i),
    .rx_valid_i (rx_valid_i),
    .rx_type_i  (rx_type_i),
    .rx_src_i   (rx_src_i),
    .rx_ptr_i   (rx_ptr_i),
    .unlink_o   (unlink),
    .rsp_ok_o   (rsp_ok),
    .nxt_null_o (nxt_null),
    .pred_o     (pred_q),
    .tgt_o      (tgt_q),
    .line_o     (tx_line_o),
    .err_o      (proto_err_o)
  );

  logic [NODE_W-1:0] next_cap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    next_cap_q <= '1;
    else if (start) next_cap_q <= own_next_i;
  end

  sinv_tx_fmt #(
    .NODE_W(NODE_W), .NODE_ID(NODE_ID), .MEM_NODE(MEM_NODE)
  ) u_fmt (
    .st_i    (st),
    .pred_i  (pred_q),
    .next_i  (next_cap_q),
    .tgt_i   (tgt_q),
    .valid_o (tx_valid_o),
    .type_o  (tx_type_o),
    .dst_o   (tx_dst_o),
    .ptr_o   (tx_ptr_o)
  );

  assign busy_o  = (st != ST_IDLE);
  assign grant_o = (st == ST_GRANT);
endmodule

// File: rtl/sinv_seq_chk.sv
module sinv_seq_chk #(
  parameter int NODE_W   = 4,
  parameter int ADDR_W   = 16,
  parameter int MEM_NODE = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_req_i,
  input logic              busy_o,
  input logic              grant_o,
  input logic              tx_valid_o,
  input logic [1:0]        tx_type_o,
  input logic [NODE_W-1:0] tx_dst_o,
  input logic [ADDR_W-1:0] tx_line_o
);
  localparam logic [NODE_W-1:0] NULL_ID = {NODE_W{1'b1}};

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tx_valid_o && !grant_o));

  assert_intent_to_mem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_type_o == 2'd1) |-> (tx_dst_o == NODE_W'(MEM_NODE)));

  assert_inval_not_null_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_type_o == 2'd2) |-> (tx_dst_o != NULL_ID));

  assert_grant_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> (!grant_o && !busy_o));

  assert_grant_no_tx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !tx_valid_o);

  assert_start_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_req_i));

  assert_single_tx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o);

  assert_line_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(tx_line_o));
endmodule

bind sinv_seq sinv_seq_chk #(
  .NODE_W(NODE_W), .ADDR_W(ADDR_W), .MEM_NODE(MEM_NODE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_req_i   (wr_req_i),
  .busy_o     (busy_o),
  .grant_o    (grant_o),
  .tx_valid_o (tx_valid_o),
  .tx_type_o  (tx_type_o),
  .tx_dst_o   (tx_dst_o),
  .tx_line_o  (tx_line_o)
);

// File: tb/tb_sinv_seq.sv
module tb_sinv_seq;
  localparam int NW = 4;
  localparam int AW = 16;
  localparam logic [NW-1:0] SELF = 4'd3;
  localparam logic [NW-1:0] MEM  = 4'd14;
  localparam logic [NW-1:0] NUL  = 4'hF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 1'b0, sharer = 1'b0, rx_valid = 1'b0;
  logic [AW-1:0] line_in = '0;
  logic [NW-1:0] pred_in = '0, next_in = '0, rx_src = '0, rx_ptr = '0;
  logic [1:0] rx_type = '0;
  logic busy, grant, perr, tx_valid;
  logic [1:0] tx_type;
  logic [NW-1:0] tx_dst, tx_ptr;
  logic [AW-1:0] tx_line;

  int n_chk = 0, n_fail = 0;
  logic [NW-1:0] lst [8];
  int len;

  always #4 clk = ~clk;

  sinv_seq #(.NODE_W(NW), .ADDR_W(AW), .NODE_ID(3), .MEM_NODE(14)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .wr_line_i(line_in),
    .is_sharer_i(sharer), .pred_i(pred_in), .own_next_i(next_in),
    .busy_o(busy), .grant_o(grant), .proto_err_o(perr),
    .tx_valid_o(tx_valid), .tx_type_o(tx_type), .tx_dst_o(tx_dst),
    .tx_ptr_o(tx_ptr), .tx_line_o(tx_line),
    .rx_valid_i(rx_valid), .rx_type_i(rx_type), .rx_src_i(rx_src), .rx_ptr_i(rx_ptr));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] exp_head(input bit sh, input logic [NW-1:0] pred);
    if (sh && pred == NUL) return SELF;
    return (len > 0) ? lst[0] : NUL;
  endfunction

  task automatic expect_tx(input string req, input logic [1:0] t, input logic [NW-1:0] d,
                           input logic [NW-1:0] p, input logic [AW-1:0] ln);
    chk(tx_valid == 1'b1, req, "tx_valid", int'(tx_valid), 1);
    chk(tx_type == t, req, "tx_type", int'(tx_type), int'(t));
    chk(tx_dst == d, req, "tx_dst", int'(tx_dst), int'(d));
    chk(tx_ptr == p, req, "tx_ptr", int'(tx_ptr), int'(p));
    chk(tx_line == ln, "R10", "tx_line", int'(tx_line), int'(ln));
    chk(grant == 1'b0, "R6", "early grant", int'(grant), 0);
  endtask

  task automatic respond(input logic [1:0] t, input logic [NW-1:0] s, input logic [NW-1:0] p,
                         input bit req_too);
    rx_valid = 1'b1; rx_type = t; rx_src = s; rx_ptr = p;
    if (req_too) begin
      wr_req = 1'b1; sharer = 1'b0; line_in = 16'hBEEF;
    end
    @(negedge clk);
    rx_valid = 1'b0; wr_req = 1'b0;
  endtask

  task automatic stray(input logic [1:0] t, input logic [NW-1:0] s);
    respond(t, s, 4'd0, 1'b0);
    chk(perr == 1'b1, "R7", "proto_err", int'(perr), 1);
    chk(tx_valid == 1'b0, "R7", "tx after stray", int'(tx_valid), 0);
  endtask

  task automatic scen(input bit sh, input logic [NW-1:0] pred, input logic [NW-1:0] mynext,
                      input logic [AW-1:0] ln, input bit strays, input bit late_req);
    logic [NW-1:0] head;
    @(negedge clk);
    wr_req = 1'b1; sharer = sh; pred_in = pred; next_in = mynext; line_in = ln;
    @(negedge clk);
    wr_req = 1'b0; line_in = ~ln;
    chk(busy == 1'b1, "R2", "busy after request", int'(busy), 1);
    if (sh && pred != NUL) begin
      expect_tx("R2", 2'd0, pred, mynext, ln);
      @(negedge clk);
      chk(tx_valid == 1'b0, "R9", "second tx", int'(tx_valid), 0);
      if (strays) stray(2'd0, pred ^ 4'd1);
      respond(2'd0, pred, 4'd0, 1'b0);
    end
    expect_tx("R3", 2'd1, MEM, SELF, ln);
    @(negedge clk);
    head = exp_head(sh, pred);
    respond(2'd1, MEM, head, late_req && (len == 0));
    for (int i = 0; i < len; i++) begin
      expect_tx((i == 0) ? "R4" : "R5", 2'd2, lst[i], SELF, ln);
      @(negedge clk);
      chk(tx_valid == 1'b0, "R9", "tx while waiting", int'(tx_valid), 0);
      if (strays && i == 0) stray(2'd2, lst[i] ^ 4'd1);
      respond(2'd2, lst[i], (i + 1 < len) ? lst[i + 1] : NUL, late_req && (i == len - 1));
    end
    chk(grant == 1'b1, "R6", "grant", int'(grant), 1);
    chk(tx_valid == 1'b0, "R6", "tx with grant", int'(tx_valid), 0);
    chk(perr == 1'b0, "R7", "spurious proto_err", int'(perr), 0);
    @(negedge clk);
    chk(grant == 1'b0, "R6", "grant width", int'(grant), 0);
    chk(busy == 1'b0, late_req ? "R8" : "R6", "busy after grant", int'(busy), 0);
    chk(tx_valid == 1'b0, "R8", "tx after grant", int'(tx_valid), 0);
  endtask

  task automatic build_list(input int n);
    len = n;
    for (int i = 0; i < n; i++) begin
      logic [NW-1:0] c;
      bit dup;
      do begin
        c = NW'($urandom_range(0, 13));
        dup = (c == SELF);
        for (int j = 0; j < i; j++) if (lst[j] == c) dup = 1'b1;
      end while (dup);
      lst[i] = c;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(tx_valid == 1'b0, "R1", "tx in reset", int'(tx_valid), 0);
    chk(grant == 1'b0, "R1", "grant in reset", int'(grant), 0);
    chk(perr == 1'b0, "R1", "err in reset", int'(perr), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // response while idle is a protocol error
    stray(2'd2, 4'd5);
    chk(busy == 1'b0, "R7", "busy after idle stray", int'(busy), 0);

    build_list(0); scen(1'b0, NUL, NUL, 16'h0001, 1'b0, 1'b0);       // immediate grant
    build_list(0); scen(1'b1, NUL, NUL, 16'h0002, 1'b0, 1'b1);       // self head, alone
    build_list(3); scen(1'b1, NUL, lst[0], 16'h0003, 1'b1, 1'b0);    // self head, walk from own next
    build_list(4); scen(1'b1, lst[2], 4'd9, 16'h0004, 1'b1, 1'b1);   // unlink then walk
    build_list(8); scen(1'b0, NUL, 4'd1, 16'hFFFF, 1'b0, 1'b1);      // long chain

    for (int k = 0; k < 40; k++) begin
      int mode;
      build_list($urandom_range(0, 8));
      mode = $urandom_range(0, 2);
      if (mode == 0)
        scen(1'b0, NW'($urandom_range(0, 15)), NW'($urandom_range(0, 15)),
             AW'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      else if (mode == 1)
        scen(1'b1, NUL, (len > 0) ? lst[0] : NUL, AW'($urandom),
             $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      else
        scen(1'b1, (len > 0) ? lst[$urandom_range(0, len - 1)] : 4'd7, NW'($urandom_range(0, 15)),
             AW'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule